// File: doc/BRIEF.md
# Sample Period Approximation Search

This block turns a requested sample period, given in nanoseconds, into the nearest period a pacing clock can actually produce. That clock is built from one of up to four master clock periods, held in a small table, followed by a power-of-two divider of 1, 2, 4 or 8. On a start pulse the unit latches the request, the rounding mode and the table. It clamps the request into the range the table can reach. It then walks every clock-by-divisor candidate, one per cycle, while keeping two running bounds: the smallest candidate at or above the request and the largest candidate at or below it.

After the last slot the unit applies the rounding mode and presents the achieved period, the clock index and the divider shift, together with a one-cycle done pulse. Typical tables are {31250, 22676, 20833, 19531} ns with four clocks and {62500, 50000, 41667} ns with three clocks. A control path uses the returned index and shift to program the real clock dividers, which are outside this block.

Top module: `period_fit`

## Requirements
- R1: Table entry j occupies bits [j*20 +: 20] of the table port. A candidate is entry j shifted left by i, with i from 0 to 3 and j below the effective clock count. Slots with j at or above that count are skipped. A count of 0 acts as 1, and a count above 4 acts as 4.
- R2: Before the search, the request is raised to the last valid entry at shift 0 if it is below that value. It is then lowered to entry 0 at shift 3 if it is above that value. The returned period always lies in this range.
- R3: The upper bound starts as entry 0 at shift 3. A candidate replaces it only when it is strictly smaller than the current bound and not below the clamped request. Candidates are visited with the shift ascending in the outer order and the clock index ascending in the inner order, so among equal values the first one found is kept.
- R4: The lower bound starts as the last valid entry at shift 0. A candidate replaces it only when it is strictly larger than the current bound and not above the clamped request. The same visiting order applies.
- R5: The rounding mode encodes 0 or 3 as nearest, 1 as up and 2 as down. Up returns the upper bound and down returns the lower bound. Nearest returns the upper bound only when its distance to the clamped request is strictly smaller, so a tie goes to the lower bound.
- R6: The clock select and divider shift outputs are those of the bound whose value was returned. When both bounds hold the same value, the upper bound's fields are used.
- R7: done is high for exactly one cycle, 17 rising edges after the edge that accepted start. period, clock select and shift change only on that edge and hold otherwise.
- R8: A start pulse that arrives while a search is running is ignored: the running search finishes with its own inputs and produces no extra done.
- R9: After reset, done is low and period, clock select and shift are all zero.
- R10: The request, mode, table and count are sampled only on the accepting edge. Changing them during the search does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search; accepted only when idle |
| req_period_i | input | 20 | Requested period in ns |
| round_mode_i | input | 2 | 0/3 nearest, 1 up, 2 down |
| tab_period_i | input | 80 | Four master clock periods, entry j at bits [j*20 +: 20] |
| tab_count_i | input | 3 | Number of valid table entries |
| done_o | output | 1 | One-cycle result strobe |
| period_o | output | 23 | Achieved period in ns |
| clk_sel_o | output | 2 | Chosen table index |
| div_shift_o | output | 2 | Chosen divider shift (divide by 2^shift) |

## Verification
Only one result exists, and it is due exactly 17 rising edges after the edge that accepted start. On that same edge the done strobe rises and the three result fields update. The bench drives its inputs on falling edges and compares done and all result fields on every falling edge of a 19-cycle window. It expects done only in the seventeenth cycle and the previous result in all other cycles. Restart pulses and input changes during the scan are placed at fixed cycles inside that window, so their lack of effect is seen in the same comparisons.

// File: rtl/period_fit_pkg.sv
package period_fit_pkg;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'd0,
    RND_UP    = 2'd1,
    RND_DOWN  = 2'd2,
    RND_NEARB = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

endpackage

// File: rtl/pf_candidate.sv
// Picks one table entry by index and scales it by a power of two.
module pf_candidate #(
  parameter int PER_W  = 20,
  parameter int NCLK   = 4,
  parameter int NSHIFT = 4,
  localparam int CI_W  = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int SH_W  = (NSHIFT > 1) ? $clog2(NSHIFT) : 1,
  localparam int CW    = PER_W + NSHIFT - 1
) (
  input  logic [NCLK*PER_W-1:0] tab_i,
  input  logic [CI_W-1:0]       ci_i,
  input  logic [SH_W-1:0]       sh_i,
  output logic [CW-1:0]         cand_o
);

  logic [PER_W-1:0] ent [NCLK];
  logic [PER_W-1:0] pick;

  for (genvar g = 0; g < NCLK; g++) begin : g_ent
    assign ent[g] = tab_i[g*PER_W +: PER_W];
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < NCLK; k++) begin
      if (ci_i == CI_W'(k)) pick = ent[k];
    end
  end

  assign cand_o = CW'(pick) << sh_i;

endmodule

// File: rtl/pf_bound.sv
// Tracks one running bound; UPPER selects least-upper or greatest-lower search.
module pf_bound #(
  parameter int CW    = 23,
  parameter int CI_W  = 2,
  parameter int SH_W  = 2,
  parameter bit UPPER = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CW-1:0]   load_val_i,
  input  logic [CI_W-1:0] load_ci_i,
  input  logic [SH_W-1:0] load_sh_i,
  input  logic            eval_i,
  input  logic [CW-1:0]   cand_i,
  input  logic [CI_W-1:0] cand_ci_i,
  input  logic [SH_W-1:0] cand_sh_i,
  input  logic [CW-1:0]   tgt_i,
  output logic [CW-1:0]   val_o,
  output logic [CI_W-1:0] ci_o,
  output logic [SH_W-1:0] sh_o
);

  logic            better;
  logic            en;
  logic [CW-1:0]   val_d;
  logic [CI_W-1:0] ci_d;
  logic [SH_W-1:0] sh_d;

  if (UPPER) begin : g_upper
    assign better = (cand_i < val_o) && (cand_i >= tgt_i);
  end else begin : g_lower
    assign better = (cand_i > val_o) && (cand_i <= tgt_i);
  end

  assign en = load_i || (eval_i && better);

  always_comb begin
    if (load_i) begin
      val_d = load_val_i;
      ci_d  = load_ci_i;
      sh_d  = load_sh_i;
    end else begin
      val_d = cand_i;
      ci_d  = cand_ci_i;
      sh_d  = cand_sh_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      ci_o  <= '0;
      sh_o  <= '0;
    end else if (en) begin
      val_o <= val_d;
      ci_o  <= ci_d;
      sh_o  <= sh_d;
    end
  end

endmodule

// File: rtl/pf_select.sv
// Applies the rounding mode to the two bounds.
module pf_select import period_fit_pkg::*; #(
  parameter int CW   = 23,
  parameter int CI_W = 2,
  parameter int SH_W = 2
) (
  input  rnd_e            mode_i,
  input  logic [CW-1:0]   tgt_i,
  input  logic [CW-1:0]   ub_val_i,
  input  logic [CI_W-1:0] ub_ci_i,
  input  logic [SH_W-1:0] ub_sh_i,
  input  logic [CW-1:0]   lb_val_i,
  input  logic [CI_W-1:0] lb_ci_i,
  input  logic [SH_W-1:0] lb_sh_i,
  output logic [CW-1:0]   per_o,
  output logic [CI_W-1:0] ci_o,
  output logic [SH_W-1:0] sh_o
);

  logic [CW-1:0] gap_up;
  logic [CW-1:0] gap_dn;
  logic          take_ub;

  assign gap_up = ub_val_i - tgt_i;
  assign gap_dn = tgt_i - lb_val_i;

  always_comb begin
    unique case (mode_i)
      RND_UP:   take_ub = 1'b1;
      RND_DOWN: take_ub = 1'b0;
      default:  take_ub = (gap_up < gap_dn);
    endcase
    per_o = take_ub ? ub_val_i : lb_val_i;
    if (per_o == ub_val_i) begin
      ci_o = ub_ci_i;
      sh_o = ub_sh_i;
    end else begin
      ci_o = lb_ci_i;
      sh_o = lb_sh_i;
    end
  end

endmodule

// File: rtl/period_fit.sv
module period_fit import period_fit_pkg::*; #(
  parameter int PER_W  = 20,
  parameter int NCLK   = 4,
  parameter int NSHIFT = 4,
  localparam int CI_W  = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int SH_W  = (NSHIFT > 1) ? $clog2(NSHIFT) : 1,
  localparam int CNT_W = $clog2(NCLK + 1),
  localparam int CW    = PER_W + NSHIFT - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PER_W-1:0]      req_period_i,
  input  logic [1:0]            round_mode_i,
  input  logic [NCLK*PER_W-1:0] tab_period_i,
  input  logic [CNT_W-1:0]      tab_count_i,
  output logic                  done_o,
  output logic [CW-1:0]         period_o,
  output logic [CI_W-1:0]       clk_sel_o,
  output logic [SH_W-1:0]       div_shift_o
);

  localparam int IDX_W = CI_W + SH_W;
  localparam int NSLOT = 1 << IDX_W;

  st_e                  state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 accept;

  logic [CNT_W-1:0]     eff_cnt;
  logic [CI_W-1:0]      last_ci;
  logic [CW-1:0]        lo_lim, hi_lim;
  logic [CW-1:0]        req_ext, clamp_a, tgt_d;

  logic [NCLK*PER_W-1:0] tab_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CW-1:0]        tgt_q;
  rnd_e                 mode_q;

  logic [CI_W-1:0]      slot_ci;
  logic [SH_W-1:0]      slot_sh;
  logic                 slot_ok;
  logic [CW-1:0]        cand;

  logic [CW-1:0]        ub_val, lb_val;
  logic [CI_W-1:0]      ub_ci, lb_ci;
  logic [SH_W-1:0]      ub_sh, lb_sh;

  logic [CW-1:0]        sel_per;
  logic [CI_W-1:0]      sel_ci;
  logic [SH_W-1:0]      sel_sh;
  logic                 res_en;

  assign accept = start_i && (state_q == ST_IDLE);

  // Effective clock count: zero acts as one, excess saturates.
  always_comb begin
    if (tab_count_i == '0)                 eff_cnt = CNT_W'(1);
    else if (tab_count_i > CNT_W'(NCLK))   eff_cnt = CNT_W'(NCLK);
    else                                   eff_cnt = tab_count_i;
  end

  assign last_ci = CI_W'(eff_cnt - CNT_W'(1));

  // Reachable range of the incoming table.
  pf_candidate #(.PER_W(PER_W), .NCLK(NCLK), .NSHIFT(NSHIFT)) u_lo (
    .tab_i (tab_period_i),
    .ci_i  (last_ci),
    .sh_i  ('0),
    .cand_o(lo_lim)
  );

  pf_candidate #(.PER_W(PER_W), .NCLK(NCLK), .NSHIFT(NSHIFT)) u_hi (
    .tab_i (tab_period_i),
    .ci_i  ('0),
    .sh_i  (SH_W'(NSHIFT - 1)),
    .cand_o(hi_lim)
  );

  assign req_ext = CW'(req_period_i);
  assign clamp_a = (req_ext < lo_lim) ? lo_lim : req_ext;
  assign tgt_d   = (clamp_a > hi_lim) ? hi_lim : clamp_a;

  // Input capture, enabled only on an accepted start.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q  <= '0;
      cnt_q  <= '0;
      tgt_q  <= '0;
      mode_q <= RND_NEAR;
    end else if (accept) begin
      tab_q  <= tab_period_i;
      cnt_q  <= eff_cnt;
      tgt_q  <= tgt_d;
      mode_q <= rnd_e'(round_mode_i);
    end
  end

  // Slot decode: shift in the upper index bits, clock in the lower.
  assign slot_ci = idx_q[CI_W-1:0];
  assign slot_sh = idx_q[IDX_W-1:CI_W];
  assign slot_ok = (state_q == ST_SCAN) && (CNT_W'(slot_ci) < cnt_q) &&
                   (32'(slot_sh) < NSHIFT);

  pf_candidate #(.PER_W(PER_W), .NCLK(NCLK), .NSHIFT(NSHIFT)) u_scan (
    .tab_i (tab_q),
    .ci_i  (slot_ci),
    .sh_i  (slot_sh),
    .cand_o(cand)
  );

  pf_bound #(.CW(CW), .CI_W(CI_W), .SH_W(SH_W), .UPPER(1'b1)) u_ub (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(hi_lim),
    .load_ci_i ('0),
    .load_sh_i (SH_W'(NSHIFT - 1)),
    .eval_i    (slot_ok),
    .cand_i    (cand),
    .cand_ci_i (slot_ci),
    .cand_sh_i (slot_sh),
    .tgt_i     (tgt_q),
    .val_o     (ub_val),
    .ci_o      (ub_ci),
    .sh_o      (ub_sh)
  );

  pf_bound #(.CW(CW), .CI_W(CI_W), .SH_W(SH_W), .UPPER(1'b0)) u_lb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(lo_lim),
    .load_ci_i (last_ci),
    .load_sh_i ('0),
    .eval_i    (slot_ok),
    .cand_i    (cand),
    .cand_ci_i (slot_ci),
    .cand_sh_i (slot_sh),
    .tgt_i     (tgt_q),
    .val_o     (lb_val),
    .ci_o      (lb_ci),
    .sh_o      (lb_sh)
  );

  // Sequencer next state.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SCAN;
          idx_d   = '0;
        end
      end
      ST_SCAN: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == IDX_W'(NSLOT - 1)) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  pf_select #(.CW(CW), .CI_W(CI_W), .SH_W(SH_W)) u_sel (
    .mode_i  (mode_q),
    .tgt_i   (tgt_q),
    .ub_val_i(ub_val),
    .ub_ci_i (ub_ci),
    .ub_sh_i (ub_sh),
    .lb_val_i(lb_val),
    .lb_ci_i (lb_ci),
    .lb_sh_i (lb_sh),
    .per_o   (sel_per),
    .ci_o    (sel_ci),
    .sh_o    (sel_sh)
  );

  assign res_en = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
    end else begin
      done_o <= res_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o    <= '0;
      clk_sel_o   <= '0;
      div_shift_o <= '0;
    end else if (res_en) begin
      period_o    <= sel_per;
      clk_sel_o   <= sel_ci;
      div_shift_o <= sel_sh;
    end
  end

endmodule

// File: rtl/pf_checker.sv
module pf_checker import period_fit_pkg::*; #(
  parameter int PER_W  = 20,
  parameter int NCLK   = 4,
  parameter int NSHIFT = 4,
  localparam int CI_W  = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int SH_W  = (NSHIFT > 1) ? $clog2(NSHIFT) : 1,
  localparam int CNT_W = $clog2(NCLK + 1),
  localparam int CW    = PER_W + NSHIFT - 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  done_o,
  input logic [CW-1:0]         period_o,
  input logic [CI_W-1:0]       clk_sel_o,
  input logic [SH_W-1:0]       div_shift_o,
  input st_e                   st_i,
  input logic [NCLK*PER_W-1:0] tab_q_i,
  input logic [CNT_W-1:0]      cnt_q_i,
  input logic [CW-1:0]         tgt_q_i,
  input rnd_e                  mode_q_i
);

  localparam int NSLOT = 1 << (CI_W + SH_W);
  localparam int LAT   = NSLOT + 2;
  localparam int LW    = $clog2(LAT + 2) + 1;

  logic [LW-1:0]    lat_q;
  logic [PER_W-1:0] sel_ent;
  logic [CW-1:0]    exp_cand;
  logic [CW-1:0]    top_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (start_i && st_i == ST_IDLE) begin
      lat_q <= LW'(1);
    end else if (lat_q != '0 && lat_q < LW'(LAT + 1)) begin
      lat_q <= lat_q + LW'(1);
    end
  end

  always_comb begin
    sel_ent = '0;
    for (int k = 0; k < NCLK; k++) begin
      if (clk_sel_o == CI_W'(k)) sel_ent = tab_q_i[k*PER_W +: PER_W];
    end
  end

  assign exp_cand = CW'(sel_ent) << div_shift_o;
  assign top_lim  = CW'(tab_q_i[PER_W-1:0]) << (NSHIFT - 1);

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(period_o) && $stable(clk_sel_o) && $stable(div_shift_o)));

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LW'(LAT)));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_i != ST_IDLE) |=> ($stable(tgt_q_i) && $stable(tab_q_i) && $stable(cnt_q_i)));

  p_candidate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (period_o == exp_cand && CNT_W'(clk_sel_o) < cnt_q_i));

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (period_o <= top_lim));

  p_round_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q_i == RND_UP) |-> (period_o >= tgt_q_i));

  p_round_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q_i == RND_DOWN) |-> (period_o <= tgt_q_i));

endmodule

bind period_fit pf_checker #(.PER_W(PER_W), .NCLK(NCLK), .NSHIFT(NSHIFT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .period_o   (period_o),
  .clk_sel_o  (clk_sel_o),
  .div_shift_o(div_shift_o),
  .st_i       (state_q),
  .tab_q_i    (tab_q),
  .cnt_q_i    (cnt_q),
  .tgt_q_i    (tgt_q),
  .mode_q_i   (mode_q)
);

// File: tb/sim_period_fit.sv
`timescale 1ns/1ps
module sim_period_fit;

  localparam int PER_W  = 20;
  localparam int NCLK   = 4;
  localparam int NSHIFT = 4;
  localparam int CW     = PER_W + NSHIFT - 1;
  localparam int DONE_K = 17;

  logic                  clk_i = 1'b0;
  logic                  rst_ni;
  logic                  start_i;
  logic [PER_W-1:0]      req_period_i;
  logic [1:0]            round_mode_i;
  logic [NCLK*PER_W-1:0] tab_period_i;
  logic [2:0]            tab_count_i;
  logic                  done_o;
  logic [CW-1:0]         period_o;
  logic [1:0]            clk_sel_o;
  logic [1:0]            div_shift_o;

  int checks = 0;
  int errors = 0;
  int old_per = 0, old_sel = 0, old_sh = 0;

  always #2.5 clk_i = ~clk_i;

  period_fit u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .req_period_i(req_period_i),
    .round_mode_i(round_mode_i),
    .tab_period_i(tab_period_i),
    .tab_count_i (tab_count_i),
    .done_o      (done_o),
    .period_o    (period_o),
    .clk_sel_o   (clk_sel_o),
    .div_shift_o (div_shift_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dut_out();
    return {8'(done_o), 32'(period_o), 8'(clk_sel_o), 16'(div_shift_o)};
  endfunction

  function automatic logic [63:0] mk(input int d, input int p, input int s, input int h);
    return {8'(d), 32'(p), 8'(s), 16'(h)};
  endfunction

  function automatic logic [NCLK*PER_W-1:0] pack_tab(input int t[4]);
    logic [NCLK*PER_W-1:0] v;
    for (int j = 0; j < 4; j++) v[j*PER_W +: PER_W] = PER_W'(t[j]);
    return v;
  endfunction

  // Behavioural reference built from the requirement text.
  task automatic model(input int req, input int mode, input int t[4], input int cnt,
                       output int per, output int sel, output int sh);
    int n, lo, hi, r, ub, ubs, ubh, lb, lbs, lbh, c;
    bit up;
    n  = (cnt == 0) ? 1 : ((cnt > 4) ? 4 : cnt);
    lo = t[n-1];
    hi = t[0] * 8;
    r  = req;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    ub = hi; ubs = 0;   ubh = 3;
    lb = lo; lbs = n-1; lbh = 0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < n; j++) begin
        c = t[j] * (1 << i);
        if (c < ub && c >= r) begin ub = c; ubs = j; ubh = i; end
        if (c > lb && c <= r) begin lb = c; lbs = j; lbh = i; end
      end
    end
    if (mode == 1)      up = 1'b1;
    else if (mode == 2) up = 1'b0;
    else                up = ((ub - r) < (r - lb));
    per = up ? ub : lb;
    if (per == ub) begin sel = ubs; sh = ubh; end
    else           begin sel = lbs; sh = lbh; end
  endtask

  // disturb: 0 none, 1 second start mid-scan, 2 inputs changed mid-scan
  task automatic run_case(input string tag, input int req, input int mode,
                          input int t[4], input int cnt, input int disturb);
    int ep, es, eh;
    model(req, mode, t, cnt, ep, es, eh);
    req_period_i = PER_W'(req);
    round_mode_i = 2'(mode);
    tab_period_i = pack_tab(t);
    tab_count_i  = 3'(cnt);
    start_i      = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 1; k <= DONE_K + 2; k++) begin
      @(negedge clk_i);
      if (k >= DONE_K)
        check({tag, " R7"}, dut_out(), mk((k == DONE_K) ? 1 : 0, ep, es, eh));
      else
        check({tag, " R7"}, dut_out(), mk(0, old_per, old_sel, old_sh));
      if (disturb == 1 && k == 5) begin
        start_i      = 1'b1;
        req_period_i = PER_W'(200000);
        round_mode_i = 2'd1;
      end
      if (disturb == 1 && k == 6) start_i = 1'b0;
      if (disturb == 2 && k == 3) begin
        req_period_i = PER_W'(999);
        round_mode_i = 2'd1;
        tab_period_i = pack_tab('{1000, 900, 800, 700});
        tab_count_i  = 3'd2;
      end
    end
    old_per = ep; old_sel = es; old_sh = eh;
  endtask

  initial begin
    int tA[4], tB[4], tD[4];
    tA = '{31250, 22676, 20833, 19531};
    tB = '{62500, 50000, 41667, 40000};
    tD = '{40000, 20000, 10000, 5000};
    rst_ni = 1'b0;
    start_i = 1'b0;
    req_period_i = '0;
    round_mode_i = '0;
    tab_period_i = '0;
    tab_count_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset state", dut_out(), mk(0, 0, 0, 0));

    run_case("R5 nearest A", 40000, 0, tA, 4, 0);
    check("R5 nearest literal", dut_out(), mk(0, 39062, 3, 1));
    run_case("R5 up A", 40000, 1, tA, 4, 0);
    check("R5 up literal", dut_out(), mk(0, 41666, 2, 1));
    run_case("R5 down A", 40000, 2, tA, 4, 0);
    run_case("R5 mode3 A", 70000, 3, tA, 4, 0);
    run_case("R5 tie A", 35156, 0, tA, 4, 0);
    check("R5 tie literal", dut_out(), mk(0, 31250, 0, 0));
    run_case("R2 clamp low", 1000, 1, tA, 4, 0);
    check("R2 low literal", dut_out(), mk(0, 19531, 3, 0));
    run_case("R2 clamp high", 900000, 2, tA, 4, 0);
    check("R2 high literal", dut_out(), mk(0, 250000, 0, 3));
    run_case("R1 skip slot B", 40000, 0, tB, 3, 0);
    check("R1 skip literal", dut_out(), mk(0, 41667, 2, 0));
    run_case("R1 count zero", 100000, 0, tA, 0, 0);
    run_case("R1 count seven", 45000, 1, tA, 7, 0);
    run_case("R3 first equal up", 39000, 1, tD, 4, 0);
    check("R3 literal", dut_out(), mk(0, 40000, 0, 0));
    run_case("R4 first equal down", 20000, 2, tD, 4, 0);
    check("R4 literal", dut_out(), mk(0, 20000, 1, 0));
    run_case("R6 fields B", 90000, 0, tB, 3, 0);
    run_case("R6 exact hit", 41666, 0, tA, 4, 0);
    run_case("R8 restart ignored", 55000, 0, tB, 3, 1);
    repeat (DONE_K + 2) begin
      @(negedge clk_i);
      check("R8 no extra done", dut_out(), mk(0, old_per, old_sel, old_sh));
    end
    run_case("R10 late input change", 60000, 2, tA, 4, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule